// File: doc/BRIEF.md
# Clock Throttling Duty Controller

This block drives an active-low stop-clock request that slows a processor by holding its clock stopped for a programmable part of every fixed-length throttle frame. The frame is a fixed number of bus clocks (1024 by default). Each frame begins with the stopped portion, and the processor runs for the rest of the frame. A 3-bit duty code sets how many clocks of the frame are stopped.

Two sources can start throttling. The first is a software force bit, which takes effect without delay. The second is an active-low thermal alarm pin. The alarm only counts once it has stayed active for a qualification window, measured in ticks of a slow timebase (two seconds in the intended system). Thermal throttling has no enable bit and cannot be switched off. A one-cycle SMI pulse marks the start of a throttle caused by the alarm. A start, a stop or a new duty value is applied only at a frame boundary. The stop-clock output is held off whenever the processor is outside its running power state.

The duty code can be written once after reset. Every later write is ignored until the next reset.

Top module: `clk_throttle_ctrl`

## Requirements
- R1: Throttling repeats with a period of FRAME_LEN clocks. In each frame `stpclk_n` is low for one contiguous run of clocks, and that run starts on the first clock of the frame.
- R2: The number of low clocks per frame is set by `duty_rd` as follows: 3'b111→128, 3'b110→256, 3'b101→384, 3'b100→512, 3'b011→640, 3'b010→768, 3'b001→896. In general this is (8−code)·FRAME_LEN/8.
- R3: Duty code 3'b000 is the reset value of `duty_rd` and gives FRAME_LEN/2 (512) low clocks per frame.
- R4: The first `duty_wr_en` after reset loads `duty_wdata` into `duty_rd`. Every later `duty_wr_en` leaves `duty_rd` unchanged until `pci_rst_n` is asserted again.
- R5: The alarm (`thrm_alarm_n` low) starts throttling only after it has stayed low across QUAL_TICKS `slow_tick` pulses without a break. If the alarm goes high, the tick count starts again from zero.
- R6: When `force_rd` is 1, throttling starts at the next frame boundary with no qualification delay and with no SMI pulse. When `force_rd` is cleared and no qualified alarm is present, throttling stops at the next frame boundary.
- R7: `smi_pulse` is high for exactly one clock, on the first clock of the first frame of a throttle that the qualified alarm started while `force_rd` was 0.
- R8: While `cpu_in_c0` is 0, `stpclk_n` stays high and `throttle_sts` reads 0.
- R9: `throttle_sts` is 1 while a throttle is in force and `cpu_in_c0` is 1, and is 0 otherwise. `stpclk_n` is never low while `throttle_sts` is 0.
- R10: A duty change, a throttle start or a throttle stop takes effect only at a frame boundary, so no shortened stop-clock pulse is produced.
- R11: After reset `stpclk_n`=1, `throttle_sts`=0, `smi_pulse`=0, `duty_rd`=0 and `force_rd`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pci_clk | input | 1 | Bus clock; the frame counts these clocks |
| pci_rst_n | input | 1 | Active-low reset; also releases the duty lock |
| duty_wr_en | input | 1 | Write strobe for the duty code |
| duty_wdata | input | DUTY_W | Duty code to write |
| force_wr_en | input | 1 | Write strobe for the force bit |
| force_wdata | input | 1 | Force bit value to write |
| thrm_alarm_n | input | 1 | Asynchronous thermal alarm, active low |
| cpu_in_c0 | input | 1 | 1 when the processor is in its running power state |
| slow_tick | input | 1 | One-clock pulse from the slow timebase |
| duty_rd | output | DUTY_W | Duty code currently held |
| force_rd | output | 1 | Force bit currently held |
| throttle_sts | output | 1 | Throttle status |
| stpclk_n | output | 1 | Stop-clock request, active low |
| smi_pulse | output | 1 | One-clock pulse at the start of an alarm-started throttle |

## Verification
The following are checked on every cycle: the power-state gating of the stop-clock and status outputs, the ordering between status and stop-clock, the rule that a stop-clock pulse may only begin at frame count zero, the single-cycle SMI pulse placed on the first clock of a frame, and the stability of a locked duty code. Other behaviour can only be shown by the bench's scenarios. These are the exact low-clock count per frame for every duty code, the write-once lock and its release by reset, and the restart of alarm qualification after a short alarm. They also cover the absence of an SMI pulse when software forces throttling, and the way throttling ends after the force bit is cleared.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // Stopped clocks per frame for a duty code; code zero maps to half the frame.
   function automatic int unsigned thr_on_clocks(input int unsigned code,
                                                 input int unsigned frame_len,
                                                 input int unsigned steps);
      if (code == 0) return frame_len / 2;
      return (steps - code) * (frame_len / steps);
   endfunction

endpackage

// File: rtl/thr_ctl_regs.sv
module thr_ctl_regs #(
   parameter int DUTY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              duty_wr_en,
   input  logic [DUTY_W-1:0] duty_wdata,
   input  logic              force_wr_en,
   input  logic              force_wdata,
   output logic [DUTY_W-1:0] duty_q,
   output logic              duty_locked,
   output logic              force_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q      <= '0;
         duty_locked <= 1'b0;
      end else if (duty_wr_en && !duty_locked) begin
         duty_q      <= duty_wdata;
         duty_locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           force_q <= 1'b0;
      else if (force_wr_en) force_q <= force_wdata;
   end

endmodule

// File: rtl/thr_alarm_qual.sv
module thr_alarm_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_TICKS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_n_async,
   input  logic slow_tick,
   output logic alarm_qual
);

   localparam int QW = $clog2(QUAL_TICKS + 1);
   localparam logic [QW-1:0] QLIM = QW'(QUAL_TICKS);

   logic alarm_act;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign alarm_act = !alarm_n_async;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], alarm_n_async};
         end
         assign alarm_act = !sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [QW-1:0] qual_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           qual_cnt <= '0;
      else if (!alarm_act)                  qual_cnt <= '0;
      else if (slow_tick && qual_cnt != QLIM) qual_cnt <= qual_cnt + 1'b1;
   end

   assign alarm_qual = alarm_act && (qual_cnt == QLIM);

endmodule

// File: rtl/thr_frame_gen.sv
module thr_frame_gen #(
   parameter int FRAME_LEN = 1024,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want_throttle,
   input  logic [CNT_W-1:0] on_len,
   output logic [CNT_W-1:0] frame_cnt,
   output logic             boundary,
   output logic             frame_active,
   output logic             stop_req
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0] on_q;

   assign boundary = (frame_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_cnt    <= '0;
         frame_active <= 1'b0;
         on_q         <= '0;
      end else begin
         frame_cnt <= boundary ? '0 : frame_cnt + 1'b1;
         if (boundary) begin
            frame_active <= want_throttle;
            on_q         <= on_len;
         end
      end
   end

   assign stop_req = frame_active && (frame_cnt < on_q);

endmodule

// File: rtl/clk_throttle_ctrl.sv
module clk_throttle_ctrl #(
   parameter int FRAME_LEN   = 1024,
   parameter int DUTY_W      = 3,
   parameter int QUAL_TICKS  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              pci_clk,
   input  logic              pci_rst_n,
   input  logic              duty_wr_en,
   input  logic [DUTY_W-1:0] duty_wdata,
   input  logic              force_wr_en,
   input  logic              force_wdata,
   input  logic              thrm_alarm_n,
   input  logic              cpu_in_c0,
   input  logic              slow_tick,
   output logic [DUTY_W-1:0] duty_rd,
   output logic              force_rd,
   output logic              throttle_sts,
   output logic              stpclk_n,
   output logic              smi_pulse
);

   localparam int STEPS = 1 << DUTY_W;
   localparam int CNT_W = $clog2(FRAME_LEN);

   generate
      if (FRAME_LEN < 2 || (FRAME_LEN % STEPS) != 0) begin : g_bad_frame
         $error("FRAME_LEN must be at least 2 and a multiple of 2**DUTY_W");
      end
      if (QUAL_TICKS < 1) begin : g_bad_qual
         $error("QUAL_TICKS must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic             duty_locked;
   logic             alarm_qual;
   logic [CNT_W-1:0] on_len;
   logic [CNT_W-1:0] frame_cnt;
   logic             boundary;
   logic             frame_active;
   logic             stop_req;
   logic             smi_q;

   thr_ctl_regs #(.DUTY_W(DUTY_W)) u_regs (
      .clk         (pci_clk),
      .rst_n       (pci_rst_n),
      .duty_wr_en  (duty_wr_en),
      .duty_wdata  (duty_wdata),
      .force_wr_en (force_wr_en),
      .force_wdata (force_wdata),
      .duty_q      (duty_rd),
      .duty_locked (duty_locked),
      .force_q     (force_rd)
   );

   thr_alarm_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_TICKS(QUAL_TICKS)) u_qual (
      .clk           (pci_clk),
      .rst_n         (pci_rst_n),
      .alarm_n_async (thrm_alarm_n),
      .slow_tick     (slow_tick),
      .alarm_qual    (alarm_qual)
   );

   assign on_len = CNT_W'(thr_pkg::thr_on_clocks(32'(duty_rd), FRAME_LEN, STEPS));

   thr_frame_gen #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_frame (
      .clk           (pci_clk),
      .rst_n         (pci_rst_n),
      .want_throttle (force_rd || alarm_qual),
      .on_len        (on_len),
      .frame_cnt     (frame_cnt),
      .boundary      (boundary),
      .frame_active  (frame_active),
      .stop_req      (stop_req)
   );

   always_ff @(posedge pci_clk or negedge pci_rst_n) begin
      if (!pci_rst_n) smi_q <= 1'b0;
      else            smi_q <= boundary && !frame_active && alarm_qual && !force_rd;
   end

   assign smi_pulse    = smi_q;
   assign stpclk_n     = !(stop_req && cpu_in_c0);
   assign throttle_sts = frame_active && cpu_in_c0;

endmodule

// File: rtl/clk_throttle_ctrl_chk.sv
module clk_throttle_ctrl_chk #(
   parameter int DUTY_W = 3,
   parameter int CNT_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_in_c0,
   input logic              stpclk_n,
   input logic              throttle_sts,
   input logic              smi_pulse,
   input logic [DUTY_W-1:0] duty_rd,
   input logic [CNT_W-1:0]  frame_cnt,
   input logic              duty_locked
);

   a_r8_c2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_in_c0 |-> (stpclk_n && !throttle_sts));

   a_r9_stop_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
      !stpclk_n |-> throttle_sts);

   a_r10_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stpclk_n) && cpu_in_c0 && $past(cpu_in_c0)) |-> (frame_cnt == '0));

   a_r7_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |=> !smi_pulse);

   a_r7_smi_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |-> (frame_cnt == '0));

   a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      duty_locked |=> ($stable(duty_rd) && duty_locked));

endmodule

bind clk_throttle_ctrl clk_throttle_ctrl_chk #(
   .DUTY_W (DUTY_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk          (pci_clk),
   .rst_n        (pci_rst_n),
   .cpu_in_c0    (cpu_in_c0),
   .stpclk_n     (stpclk_n),
   .throttle_sts (throttle_sts),
   .smi_pulse    (smi_pulse),
   .duty_rd      (duty_rd),
   .frame_cnt    (frame_cnt),
   .duty_locked  (duty_locked)
);

// File: tb/clk_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module clk_throttle_ctrl_bench;

   localparam int FRAME = 1024;
   localparam int QT    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       duty_wr_en = 1'b0;
   logic [2:0] duty_wdata = '0;
   logic       force_wr_en = 1'b0;
   logic       force_wdata = 1'b0;
   logic       thrm_alarm_n = 1'b1;
   logic       cpu_in_c0 = 1'b1;
   logic       slow_tick = 1'b0;
   logic [2:0] duty_rd;
   logic       force_rd;
   logic       throttle_sts;
   logic       stpclk_n;
   logic       smi_pulse;

   int checks = 0;
   int errors = 0;
   int smi_count = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_throttle_ctrl #(.FRAME_LEN(FRAME), .DUTY_W(3), .QUAL_TICKS(QT), .SYNC_STAGES(2))
   u_clk_throttle_ctrl (
      .pci_clk(clk), .pci_rst_n(rst_n), .duty_wr_en(duty_wr_en), .duty_wdata(duty_wdata),
      .force_wr_en(force_wr_en), .force_wdata(force_wdata), .thrm_alarm_n(thrm_alarm_n),
      .cpu_in_c0(cpu_in_c0), .slow_tick(slow_tick), .duty_rd(duty_rd), .force_rd(force_rd),
      .throttle_sts(throttle_sts), .stpclk_n(stpclk_n), .smi_pulse(smi_pulse)
   );

   always @(negedge clk) if (rst_n && smi_pulse) smi_count++;

   // duty code and expected stopped clocks per frame
   localparam int VCODE [8] = '{1, 2, 3, 4, 5, 6, 7, 0};
   localparam int VON   [8] = '{896, 768, 640, 512, 384, 256, 128, 512};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      smi_count = 0;
      rst_n = 1'b1;
   endtask

   task automatic wr_duty(input logic [2:0] v);
      @(negedge clk); duty_wr_en = 1'b1; duty_wdata = v;
      @(negedge clk); duty_wr_en = 1'b0;
   endtask

   task automatic wr_force(input logic v);
      @(negedge clk); force_wr_en = 1'b1; force_wdata = v;
      @(negedge clk); force_wr_en = 1'b0;
   endtask

   task automatic give_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         repeat (5) @(negedge clk);
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
      end
   endtask

   // Window of one frame, aligned to the first stop-clock fall if one is seen.
   task automatic measure(output int lows, output int rises);
      logic prev;
      bit   found = 1'b0;
      lows = 0; rises = 0;
      @(negedge clk); prev = stpclk_n;
      for (int k = 0; k < 2 * FRAME && !found; k++) begin
         @(negedge clk);
         if (prev && !stpclk_n) found = 1'b1;
         else prev = stpclk_n;
      end
      prev = 1'b0;
      for (int k = 0; k < FRAME; k++) begin
         if (k > 0) @(negedge clk);
         if (!stpclk_n) lows++;
         if (k > 0 && !prev && stpclk_n) rises++;
         prev = stpclk_n;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int lows, rises;
      do_reset();
      @(negedge clk);
      // R11 reset state
      chk("R11 stpclk_n", stpclk_n, 1);
      chk("R11 throttle_sts", throttle_sts, 0);
      chk("R11 smi_pulse", smi_pulse, 0);
      chk("R11 duty_rd", duty_rd, 0);
      chk("R11 force_rd", force_rd, 0);

      // vector walk: R1 R2 R3 R6 R9 R10
      for (int i = 0; i < 8; i++) begin
         do_reset();
         wr_duty(3'(VCODE[i]));
         repeat (37 * i + 11) @(negedge clk);
         wr_force(1'b1);
         measure(lows, rises);
         chk(VCODE[i] == 0 ? "R3 low clocks" : "R2 low clocks", lows, VON[i]);
         chk("R1 R10 single contiguous run", rises, 1);
         chk("R9 status while forced", throttle_sts, 1);
         chk("R6 no smi on force", smi_count, 0);
      end

      // R3 default code without any write
      do_reset();
      wr_force(1'b1);
      measure(lows, rises);
      chk("R3 default low clocks", lows, 512);

      // R6 clearing force stops at boundary
      wr_force(1'b0);
      repeat (FRAME + 4) @(negedge clk);
      measure(lows, rises);
      chk("R6 stop after clear", lows, 0);
      chk("R9 status after clear", throttle_sts, 0);

      // R4 write once, reset releases
      do_reset();
      wr_duty(3'b011);
      wr_duty(3'b110);
      chk("R4 second write ignored", duty_rd, 3);
      wr_force(1'b1);
      measure(lows, rises);
      chk("R4 locked duty in effect", lows, 640);
      do_reset();
      chk("R4 reset clears duty", duty_rd, 0);
      wr_duty(3'b110);
      chk("R4 write after reset", duty_rd, 6);

      // R8 gating outside C0
      wr_force(1'b1);
      cpu_in_c0 = 1'b0;
      repeat (FRAME + 4) @(negedge clk);
      measure(lows, rises);
      chk("R8 no stop outside C0", lows, 0);
      chk("R8 status outside C0", throttle_sts, 0);
      cpu_in_c0 = 1'b1;
      measure(lows, rises);
      chk("R8 resumes in C0", lows, 256);

      // R5 R7 alarm qualification
      do_reset();
      wr_duty(3'b101);
      thrm_alarm_n = 1'b0;
      give_ticks(QT - 1);
      repeat (2 * FRAME + 8) @(negedge clk);
      chk("R5 short alarm no throttle", throttle_sts, 0);
      thrm_alarm_n = 1'b1;
      repeat (6) @(negedge clk);
      thrm_alarm_n = 1'b0;
      give_ticks(QT - 1);
      repeat (2 * FRAME + 8) @(negedge clk);
      chk("R5 count restarts", throttle_sts, 0);
      chk("R7 no smi before qualify", smi_count, 0);
      give_ticks(1);
      measure(lows, rises);
      chk("R5 qualified low clocks", lows, 384);
      chk("R9 status on alarm", throttle_sts, 1);
      chk("R7 one smi pulse", smi_count, 1);
      measure(lows, rises);
      chk("R7 still one smi", smi_count, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule